// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Direct Kernel Window

This block turns 32-bit virtual addresses into physical addresses for one cycle of a load/store pipeline. It holds a small, fully associative set of page translations, each tagged with an address-space identifier and a global flag. A lookup carries the current identifier. A non-global entry answers only to its own identifier. A global entry answers to every identifier. A context switch therefore needs no flush: the pipeline just changes the identifier it presents. Several entries may cover the same virtual page under different identifiers at the same time.

Addresses in a fixed 512 MB kernel window are translated arithmetically, without the entry array. The window is always on. A small cache-mode register supplies the attribute reported for it. Outside the window, a lookup that finds no entry reports a miss. The page walk and the choice of which slot to refill belong to the surrounding logic, which installs entries through an indexed write port. Two flush controls clear entries: one spares global entries while the global-enable control is set, the other clears everything.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid. The cache-mode register holds its reset value (parameter, default 2).
- R2: A write to a slot takes effect at the next clock edge. After that, a lookup at that page returns hit=1, physical address = {stored frame, low 12 address bits}, and the stored attribute. Pages are 4 KB and there are 16 slots.
- R3: A non-global entry matches only when its identifier equals the lookup identifier. Under any other identifier the same address misses, and no flush is needed.
- R4: A global entry matches on the page number alone, whatever the lookup identifier.
- R5: Entries with the same page number but different identifiers coexist. Each identifier gets its own frame, and the multiple-match flag stays 0.
- R6: Outside the window, a miss drives hit, physical address, attribute and multiple-match flag all to 0.
- R7: When more than one valid entry matches a lookup, the multiple-match flag is 1 and the lowest-numbered matching slot supplies the result.
- R8: A local flush while global-enable is 1 keeps the valid entries marked global and invalidates all others at the next edge.
- R9: A local flush while global-enable is 0 invalidates every entry.
- R10: A full flush invalidates every entry, whatever global-enable holds.
- R11: A write in the same cycle as either flush is dropped.
- R12: Addresses 0x80000000 through 0x9FFFFFFF always give hit=1, physical address = address - 0x80000000, attribute = cache-mode register, multiple-match 0, even when an entry covers that page. The addresses 0x7FFFFFFF and 0xA0000000 go through the entry array.
- R13: A cache-mode write loads the value at the next edge. Window lookups after that edge report the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_hit | output | 1 | Translation found (array hit or window) |
| lk_paddr | output | 32 | Translated physical address, 0 on miss |
| lk_attr | output | ATTR_W | Page attribute or window cache mode, 0 on miss |
| lk_multi | output | 1 | More than one entry matched |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | log2(ENTRIES) | Slot to write |
| wr_vpn | input | 32-PAGE_W | Virtual page number |
| wr_asid | input | ASID_W | Identifier tag |
| wr_global | input | 1 | Global flag |
| wr_pfn | input | 32-PAGE_W | Physical frame number |
| wr_attr | input | ATTR_W | Page attribute |
| flush_local | input | 1 | Flush non-global entries (all if global-enable is 0) |
| flush_all | input | 1 | Flush every entry |
| glob_en | input | 1 | Global-enable control |
| cmode_we | input | 1 | Load the window cache-mode register |
| cmode_wdata | input | ATTR_W | New window cache mode |

## Verification
A corrupted valid bit or tag shows at the ports on the first lookup of that page after the edge that corrupted it. It appears as an unexpected hit, a miss, or a frame that belongs to another identifier. A flush that spares too much, or a write that slips past a flush, shows one cycle after the flush as a surviving translation. A wrong priority order shows as a foreign frame next to a raised multiple-match flag, in the same cycle as the lookup. Window errors need no history: any address in the window shows them at once in the physical address or attribute.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W       = 32;
  localparam int unsigned KWIN_LOG2  = 29;
  localparam logic [2:0]  KWIN_TOP   = 3'b100;

  // Address falls inside the fixed direct-mapped kernel window.
  function automatic logic in_kwin(input logic [VA_W-1:0] va);
    return va[VA_W-1:KWIN_LOG2] == KWIN_TOP;
  endfunction

  // Window translation: strip the window base by masking the top bits.
  function automatic logic [VA_W-1:0] kwin_phys(input logic [VA_W-1:0] va);
    return {{(VA_W-KWIN_LOG2){1'b0}}, va[KWIN_LOG2-1:0]};
  endfunction

  // Mask of all bit positions below idx.
  function automatic logic [63:0] below_mask(input int unsigned idx);
    return (64'd1 << idx) - 64'd1;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned ATTR_W  = 3,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [ASID_W-1:0]              wr_asid,
  input  logic                           wr_global,
  input  logic [VPN_W-1:0]               wr_pfn,
  input  logic [ATTR_W-1:0]              wr_attr,
  input  logic                           flush_local,
  input  logic                           flush_all,
  input  logic                           glob_en,
  output logic [ENTRIES-1:0]             ent_vld,
  output logic [ENTRIES-1:0]             ent_glb,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_pfn,
  output logic [ENTRIES-1:0][ATTR_W-1:0] ent_attr
);
  // Named internal events for the checks below.
  logic flush_any;
  logic wr_take;
  assign flush_any = flush_local | flush_all;
  assign wr_take   = wr_en & ~flush_any;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = wr_take && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)            ent_vld[i] <= 1'b0;
      else if (flush_all)    ent_vld[i] <= 1'b0;
      else if (flush_local)  ent_vld[i] <= ent_vld[i] & glob_en & ent_glb[i];
      else if (sel)          ent_vld[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_glb[i]  <= 1'b0;
        ent_vpn[i]  <= '0;
        ent_asid[i] <= '0;
        ent_pfn[i]  <= '0;
        ent_attr[i] <= '0;
      end else if (sel) begin
        ent_glb[i]  <= wr_global;
        ent_vpn[i]  <= wr_vpn;
        ent_asid[i] <= wr_asid;
        ent_pfn[i]  <= wr_pfn;
        ent_attr[i] <= wr_attr;
      end
    end
  end

  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> ent_vld == '0);
  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> ent_vld[$past(wr_idx)]);
  a_r8_global_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all && glob_en) |=> ent_vld == ($past(ent_vld) & $past(ent_glb)));
  a_r9_local_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !glob_en) |=> ent_vld == '0);
  a_r10_flush_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> ent_vld == '0);
  a_r11_flush_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> ($stable(ent_pfn) && $stable(ent_vpn) && $stable(ent_glb)));
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8
) (
  input  logic [VPN_W-1:0]               lk_vpn,
  input  logic [ASID_W-1:0]              lk_asid,
  input  logic [ENTRIES-1:0]             ent_vld,
  input  logic [ENTRIES-1:0]             ent_glb,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  output logic [ENTRIES-1:0]             match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic page_eq;
    logic tag_ok;
    assign page_eq  = ent_vpn[i] == lk_vpn;
    assign tag_ok   = ent_glb[i] || (ent_asid[i] == lk_asid);
    assign match[i] = ent_vld[i] && page_eq && tag_ok;
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] match,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic               multi
);
  import tlb_pkg::*;

  // Lowest index wins: scan from the top so the last assignment is the lowest.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // More than one bit set: clearing the lowest set bit leaves something.
  assign multi = (match & (match - ENTRIES'(1))) != '0;

  a_r7_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> match[idx]);
  a_r7_nothing_lower: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (match & ENTRIES'(below_mask(idx))) == '0);
  a_r7_single_is_not_multi: assert property (@(posedge clk) disable iff (!rst_n)
    !multi |-> $onehot0(match));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned ATTR_W    = 3,
  parameter int unsigned PAGE_W    = 12,
  parameter logic [ATTR_W-1:0] CMODE_RST = ATTR_W'(2),
  localparam int unsigned VA_W     = tlb_pkg::VA_W,
  localparam int unsigned VPN_W    = VA_W - PAGE_W,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [VA_W-1:0]   lk_paddr,
  output logic [ATTR_W-1:0] lk_attr,
  output logic              lk_multi,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [VPN_W-1:0]  wr_pfn,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              flush_local,
  input  logic              flush_all,
  input  logic              glob_en,
  input  logic              cmode_we,
  input  logic [ATTR_W-1:0] cmode_wdata
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0]             ent_glb;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_pfn;
  logic [ENTRIES-1:0][ATTR_W-1:0] ent_attr;
  logic [ENTRIES-1:0]             match;
  logic                           arr_hit;
  logic                           arr_multi;
  logic [IDX_W-1:0]               sel_idx;
  logic                           in_win;
  logic [ATTR_W-1:0]              cmode_q;

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .ATTR_W(ATTR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_attr(wr_attr),
    .flush_local(flush_local), .flush_all(flush_all), .glob_en(glob_en),
    .ent_vld(ent_vld), .ent_glb(ent_glb), .ent_vpn(ent_vpn),
    .ent_asid(ent_asid), .ent_pfn(ent_pfn), .ent_attr(ent_attr)
  );

  tlb_cmp #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
  ) u_cmp (
    .lk_vpn(lk_vaddr[VA_W-1:PAGE_W]), .lk_asid(lk_asid),
    .ent_vld(ent_vld), .ent_glb(ent_glb), .ent_vpn(ent_vpn),
    .ent_asid(ent_asid), .match(match)
  );

  tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk(clk), .rst_n(rst_n), .match(match),
    .any(arr_hit), .idx(sel_idx), .multi(arr_multi)
  );

  // Window cache-mode register: the window's only setting.
  always_ff @(posedge clk) begin
    if (!rst_n)        cmode_q <= CMODE_RST;
    else if (cmode_we) cmode_q <= cmode_wdata;
  end

  assign in_win = in_kwin(lk_vaddr);

  always_comb begin
    lk_hit   = 1'b0;
    lk_paddr = '0;
    lk_attr  = '0;
    lk_multi = 1'b0;
    if (in_win) begin
      lk_hit   = 1'b1;
      lk_paddr = kwin_phys(lk_vaddr);
      lk_attr  = cmode_q;
    end else if (arr_hit) begin
      lk_hit   = 1'b1;
      lk_paddr = {ent_pfn[sel_idx], lk_vaddr[PAGE_W-1:0]};
      lk_attr  = ent_attr[sel_idx];
      lk_multi = arr_multi;
    end
  end

  a_r1_cmode_reset: assert property (@(posedge clk)
    !rst_n |=> cmode_q == CMODE_RST);
  a_r3_tag_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !in_win) |-> (ent_glb[sel_idx] || ent_asid[sel_idx] == lk_asid));
  a_r6_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0 && lk_attr == '0 && !lk_multi));
  a_r7_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);
  a_r12_window_direct: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> (lk_hit && !lk_multi && lk_attr == cmode_q
                && lk_paddr == lk_vaddr - 32'h8000_0000));
  a_r13_cmode_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmode_we |=> cmode_q == $past(cmode_wdata));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_attr;
  logic        lk_multi;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn = '0;
  logic [2:0]  wr_attr = '0;
  logic        flush_local = 1'b0;
  logic        flush_all = 1'b0;
  logic        glob_en = 1'b0;
  logic        cmode_we = 1'b0;
  logic [2:0]  cmode_wdata = '0;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_attr(lk_attr), .lk_multi(lk_multi),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_attr(wr_attr),
    .flush_local(flush_local), .flush_all(flush_all), .glob_en(glob_en),
    .cmode_we(cmode_we), .cmode_wdata(cmode_wdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Lookup away from the clock edge, then compare all four outputs.
  task automatic look(input string req, input logic [31:0] va, input logic [7:0] asid,
                      input logic ehit, input logic [31:0] epa,
                      input logic [2:0] eattr, input logic emulti);
    @(negedge clk);
    lk_vaddr = va;
    lk_asid  = asid;
    #1;
    chk(req, "hit",   {31'd0, lk_hit},   {31'd0, ehit});
    chk(req, "paddr", lk_paddr,          epa);
    chk(req, "attr",  {29'd0, lk_attr},  {29'd0, eattr});
    chk(req, "multi", {31'd0, lk_multi}, {31'd0, emulti});
  endtask

  task automatic put(input logic [3:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                     input logic g, input logic [19:0] pfn, input logic [2:0] attr);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid;
    wr_global = g; wr_pfn = pfn; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_flush(input logic loc, input logic all, input logic ge);
    @(negedge clk);
    glob_en = ge; flush_local = loc; flush_all = all;
    @(negedge clk);
    flush_local = 1'b0; flush_all = 1'b0;
  endtask

  task automatic t_reset;
    look("R1", 32'h0000_1000, 8'h00, 1'b0, 32'h0, 3'd0, 1'b0);
    look("R1", 32'h8000_1234, 8'h00, 1'b1, 32'h0000_1234, 3'd2, 1'b0);
  endtask

  task automatic t_install;
    put(4'd3, 20'h12345, 8'd5, 1'b0, 20'hABCDE, 3'd5);
    look("R2", 32'h1234_5678, 8'd5, 1'b1, 32'hABCD_E678, 3'd5, 1'b0);
    look("R3", 32'h1234_5678, 8'd6, 1'b0, 32'h0, 3'd0, 1'b0);
    look("R6", 32'h1234_6678, 8'd5, 1'b0, 32'h0, 3'd0, 1'b0);
  endtask

  task automatic t_global;
    put(4'd7, 20'h00400, 8'd1, 1'b1, 20'h00777, 3'd1);
    look("R4", 32'h0040_0ABC, 8'h33, 1'b1, 32'h0077_7ABC, 3'd1, 1'b0);
    look("R4", 32'h0040_0ABC, 8'h01, 1'b1, 32'h0077_7ABC, 3'd1, 1'b0);
  endtask

  task automatic t_shared_page;
    put(4'd8, 20'h12345, 8'd9, 1'b0, 20'h11111, 3'd2);
    look("R5", 32'h1234_5678, 8'd9, 1'b1, 32'h1111_1678, 3'd2, 1'b0);
    look("R5", 32'h1234_5678, 8'd5, 1'b1, 32'hABCD_E678, 3'd5, 1'b0);
  endtask

  task automatic t_multi;
    put(4'd10, 20'h12345, 8'd5, 1'b0, 20'h22222, 3'd4);
    look("R7", 32'h1234_5678, 8'd5, 1'b1, 32'hABCD_E678, 3'd5, 1'b1);
    put(4'd2, 20'h12345, 8'd5, 1'b0, 20'h33333, 3'd6);
    look("R7", 32'h1234_5678, 8'd5, 1'b1, 32'h3333_3678, 3'd6, 1'b1);
  endtask

  task automatic t_window;
    @(negedge clk);
    cmode_we = 1'b1; cmode_wdata = 3'd6;
    @(negedge clk);
    cmode_we = 1'b0;
    look("R13", 32'h8000_0000, 8'h00, 1'b1, 32'h0000_0000, 3'd6, 1'b0);
    put(4'd12, 20'h80000, 8'd0, 1'b0, 20'h55555, 3'd1);
    look("R12", 32'h8000_0010, 8'h00, 1'b1, 32'h0000_0010, 3'd6, 1'b0);
    look("R12", 32'h9FFF_FFFF, 8'h00, 1'b1, 32'h1FFF_FFFF, 3'd6, 1'b0);
    look("R12", 32'h7FFF_FFFF, 8'h00, 1'b0, 32'h0, 3'd0, 1'b0);
    put(4'd13, 20'hA0000, 8'd0, 1'b1, 20'h00042, 3'd3);
    look("R12", 32'hA000_0000, 8'd7, 1'b1, 32'h0004_2000, 3'd3, 1'b0);
  endtask

  task automatic t_flush_local_keep;
    pulse_flush(1'b1, 1'b0, 1'b1);
    look("R8", 32'h0040_0ABC, 8'h33, 1'b1, 32'h0077_7ABC, 3'd1, 1'b0);
    look("R8", 32'h1234_5678, 8'd5, 1'b0, 32'h0, 3'd0, 1'b0);
    look("R8", 32'h1234_5678, 8'd9, 1'b0, 32'h0, 3'd0, 1'b0);
  endtask

  task automatic t_flush_local_all;
    pulse_flush(1'b1, 1'b0, 1'b0);
    look("R9", 32'h0040_0ABC, 8'h33, 1'b0, 32'h0, 3'd0, 1'b0);
    look("R9", 32'hA000_0000, 8'd7, 1'b0, 32'h0, 3'd0, 1'b0);
    look("R12", 32'h8000_0010, 8'h00, 1'b1, 32'h0000_0010, 3'd6, 1'b0);
  endtask

  task automatic t_flush_all;
    put(4'd7, 20'h00400, 8'd1, 1'b1, 20'h00777, 3'd1);
    look("R4", 32'h0040_0ABC, 8'h02, 1'b1, 32'h0077_7ABC, 3'd1, 1'b0);
    pulse_flush(1'b0, 1'b1, 1'b1);
    look("R10", 32'h0040_0ABC, 8'h02, 1'b0, 32'h0, 3'd0, 1'b0);
  endtask

  task automatic t_flush_beats_write;
    @(negedge clk);
    glob_en = 1'b1; flush_local = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd4; wr_vpn = 20'h00111; wr_asid = 8'd0;
    wr_global = 1'b1; wr_pfn = 20'h00999; wr_attr = 3'd7;
    @(negedge clk);
    flush_local = 1'b0; wr_en = 1'b0;
    look("R11", 32'h0011_1000, 8'd0, 1'b0, 32'h0, 3'd0, 1'b0);
    put(4'd4, 20'h00111, 8'd0, 1'b1, 20'h00999, 3'd7);
    look("R11", 32'h0011_1000, 8'd0, 1'b1, 32'h0099_9000, 3'd7, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_install();
    t_global();
    t_shared_page();
    t_multi();
    t_window();
    t_flush_local_keep();
    t_flush_local_all();
    t_flush_all();
    t_flush_beats_write();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule